// File: doc/BRIEF.md
# Electrode Contact Fault Qualifier

This block judges whether the electrode loop of a stimulation channel can be trusted. It watches sampled loop current and loop voltage words, each qualified by a sample strobe, together with the commanded current. From these it decides whether the contact looks open, shorted, drifting toward high impedance, or out of step with the command. Every decision uses programmable thresholds. Each threshold pair gives hysteresis: one level sets the condition and a looser level holds it.

Open and short faults are declared only when enough recent samples agree. A fault needs at least N hits among the last M qualified samples, so a single spike cannot trip it. A blanking request marks a connector event or an output step. It opens a window in which samples are thrown away and all history is wiped. After blanking, or after any unclean sample, a run of clean samples must complete before the loop is reported good again. The high-impedance band is found by comparing voltage against current scaled by small multipliers, so no divider is needed.

Top module: `contact_qualifier`

## Requirements
- R1: During and right after reset, every output (loop_ok, warn_derate, open_flt, short_flt, mismatch, confirm_done) is low.
- R2: A qualified sample is an open hit when v_meas >= open_v_set and i_meas <= open_i_set. After a hit, the next sample stays a hit while v_meas >= open_v_clr and i_meas <= open_i_clr.
- R3: A qualified sample is a short hit when v_meas <= short_v_set and i_meas >= short_i_set. After a hit, the next sample stays a hit while v_meas <= short_v_clr and i_meas >= short_i_clr.
- R4: open_flt (and likewise short_flt) is high exactly when at least N_HIT (default 5) of the last M_WIN (default 8) qualified samples were hits. Isolated hits below that count never raise it.
- R5: warn_derate rises on a qualified sample with v_meas > i_meas*warn_k_set and stays high while v_meas > i_meas*warn_k_clr. It never lowers loop_ok.
- R6: mismatch rises on a qualified sample with |i_meas - i_cmd| > tol_set and stays high while |i_meas - i_cmd| > tol_clr. While it is high, loop_ok is low.
- R7: A blanking request in one cycle blanks that cycle and the following BLANK_CYC (default 16) cycles. A sample strobed in a blanked cycle is ignored. In every blanked cycle the hit history, the hysteresis states and the clean-run count are cleared, so all outputs are low after it.
- R8: confirm_done goes high on the CONF_N-th (default 4) consecutive clean qualified sample after reset or blanking. A clean sample is neither an open hit, a short hit, nor a mismatch hit. Any unclean sample restarts the count.
- R9: loop_ok is high exactly when confirm_done is high and open_flt, short_flt and mismatch are all low.
- R10: Outputs change only on the clock edge after a qualified sample or a blanked cycle. Cycles with no strobe and no blanking leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe for i_meas and v_meas |
| i_meas | input | DW | Measured loop current |
| v_meas | input | DW | Measured loop voltage |
| i_cmd | input | DW | Commanded current |
| blank_req | input | 1 | Start or restart the blanking window |
| open_v_set | input | DW | Open: voltage level that sets |
| open_v_clr | input | DW | Open: voltage level that holds |
| open_i_set | input | DW | Open: current level that sets |
| open_i_clr | input | DW | Open: current level that holds |
| short_v_set | input | DW | Short: voltage level that sets |
| short_v_clr | input | DW | Short: voltage level that holds |
| short_i_set | input | DW | Short: current level that sets |
| short_i_clr | input | DW | Short: current level that holds |
| warn_k_set | input | KW | Impedance warning multiplier, set |
| warn_k_clr | input | KW | Impedance warning multiplier, hold |
| tol_set | input | DW | Mismatch tolerance, set |
| tol_clr | input | DW | Mismatch tolerance, hold |
| loop_ok | output | 1 | Loop trusted for stimulation |
| warn_derate | output | 1 | High-impedance warning: derate and re-apply electrodes |
| open_flt | output | 1 | Qualified open fault |
| short_flt | output | 1 | Qualified short fault |
| mismatch | output | 1 | Current differs from command |
| confirm_done | output | 1 | Clean re-confirmation run complete |

## Verification
The bench first runs directed patterns. A steady nominal load shows the re-confirm count reaching loop_ok. Sparse open spikes show that sub-threshold hits never make a fault, and a sustained open shows that they do. Values inside the hysteresis band show that a held condition persists. An open burst placed inside a blanking window shows that those samples leave no trace and that confirmation starts over. Separate warning, mismatch and short loads tell apart the condition that only warns from the two that withdraw permission. A long pseudo-random mix of loads, idle cycles and blanking requests then stresses the window arithmetic at every alignment.

// File: rtl/cq_pkg.sv
package cq_pkg;
  // Rising compare with hysteresis: x must reach set_lvl to start,
  // and stays asserted while it reaches clr_lvl.
  function automatic logic ge_hyst(input logic held, input int unsigned x,
                                   input int unsigned set_lvl, input int unsigned clr_lvl);
    return held ? (x >= clr_lvl) : (x >= set_lvl);
  endfunction

  // Falling compare with hysteresis.
  function automatic logic le_hyst(input logic held, input int unsigned x,
                                   input int unsigned set_lvl, input int unsigned clr_lvl);
    return held ? (x <= clr_lvl) : (x <= set_lvl);
  endfunction

  // Strict rising compare with hysteresis.
  function automatic logic gt_hyst(input logic held, input int unsigned x,
                                   input int unsigned set_lvl, input int unsigned clr_lvl);
    return held ? (x > clr_lvl) : (x > set_lvl);
  endfunction

  function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/cq_blank_timer.sv
module cq_blank_timer #(
  parameter int BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic blanking
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (trig)           cnt <= CW'(BLANK_CYC);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign blanking = trig || (cnt != '0);
endmodule

// File: rtl/cq_window.sv
module cq_window #(
  parameter int M_WIN = 8,
  parameter int N_HIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic hit,
  output logic flt
);
  logic [M_WIN-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) hist <= '0;
    else if (push)     hist <= {hist[M_WIN-2:0], hit};
  end

  assign flt = ($countones(hist) >= N_HIT);
endmodule

// File: rtl/cq_confirm.sv
module cq_confirm #(
  parameter int CONF_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic clean,
  output logic done
);
  localparam int CW = $clog2(CONF_N + 1);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)          run <= '0;
    else if (push) begin
      if (!clean)               run <= '0;
      else if (run != CW'(CONF_N)) run <= run + CW'(1);
    end
  end

  assign done = (run == CW'(CONF_N));
endmodule

// File: rtl/contact_qualifier.sv
module contact_qualifier #(
  parameter int DW        = 12,
  parameter int KW        = 4,
  parameter int M_WIN     = 8,
  parameter int N_HIT     = 5,
  parameter int BLANK_CYC = 16,
  parameter int CONF_N    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] i_meas,
  input  logic [DW-1:0] v_meas,
  input  logic [DW-1:0] i_cmd,
  input  logic          blank_req,
  input  logic [DW-1:0] open_v_set,
  input  logic [DW-1:0] open_v_clr,
  input  logic [DW-1:0] open_i_set,
  input  logic [DW-1:0] open_i_clr,
  input  logic [DW-1:0] short_v_set,
  input  logic [DW-1:0] short_v_clr,
  input  logic [DW-1:0] short_i_set,
  input  logic [DW-1:0] short_i_clr,
  input  logic [KW-1:0] warn_k_set,
  input  logic [KW-1:0] warn_k_clr,
  input  logic [DW-1:0] tol_set,
  input  logic [DW-1:0] tol_clr,
  output logic          loop_ok,
  output logic          warn_derate,
  output logic          open_flt,
  output logic          short_flt,
  output logic          mismatch,
  output logic          confirm_done
);
  import cq_pkg::*;

  localparam int NCOND = 2;  // index 0 = open, 1 = short

  // Named internal events, brought out for the checker.
  logic blanking;
  logic qual;
  logic open_hit, short_hit, warn_hit, mm_hit;
  logic clean;

  // Hysteresis state per condition.
  logic open_h, short_h, warn_h, mm_h;

  int unsigned iv, vv, cv;
  assign iv = 32'(i_meas);
  assign vv = 32'(v_meas);
  assign cv = 32'(i_cmd);

  cq_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .trig(blank_req), .blanking(blanking)
  );

  assign qual = smp_vld && !blanking;

  assign open_hit  = ge_hyst(open_h, vv, 32'(open_v_set), 32'(open_v_clr))
                  && le_hyst(open_h, iv, 32'(open_i_set), 32'(open_i_clr));
  assign short_hit = le_hyst(short_h, vv, 32'(short_v_set), 32'(short_v_clr))
                  && ge_hyst(short_h, iv, 32'(short_i_set), 32'(short_i_clr));
  assign warn_hit  = gt_hyst(warn_h, vv, iv * 32'(warn_k_set), iv * 32'(warn_k_clr));
  assign mm_hit    = gt_hyst(mm_h, abs_diff(iv, cv), 32'(tol_set), 32'(tol_clr));
  assign clean     = !open_hit && !short_hit && !mm_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || blanking) begin
      open_h  <= 1'b0;
      short_h <= 1'b0;
      warn_h  <= 1'b0;
      mm_h    <= 1'b0;
    end else if (qual) begin
      open_h  <= open_hit;
      short_h <= short_hit;
      warn_h  <= warn_hit;
      mm_h    <= mm_hit;
    end
  end

  // N-of-M persistence, one window per fault condition.
  logic [NCOND-1:0] cond_hit;
  logic [NCOND-1:0] cond_flt;
  assign cond_hit = {short_hit, open_hit};

  for (genvar g = 0; g < NCOND; g++) begin : g_win
    cq_window #(.M_WIN(M_WIN), .N_HIT(N_HIT)) u_win (
      .clk(clk), .rst_n(rst_n), .clr(blanking), .push(qual),
      .hit(cond_hit[g]), .flt(cond_flt[g])
    );
  end

  cq_confirm #(.CONF_N(CONF_N)) u_conf (
    .clk(clk), .rst_n(rst_n), .clr(blanking), .push(qual),
    .clean(clean), .done(confirm_done)
  );

  assign open_flt    = cond_flt[0];
  assign short_flt   = cond_flt[1];
  assign mismatch    = mm_h;
  assign warn_derate = warn_h;
  assign loop_ok     = confirm_done && !open_flt && !short_flt && !mismatch;
endmodule

// File: rtl/cq_checker.sv
module cq_checker (
  input logic clk,
  input logic rst_n,
  input logic blank_req,
  input logic smp_vld,
  input logic blanking,
  input logic qual,
  input logic open_hit,
  input logic short_hit,
  input logic loop_ok,
  input logic warn_derate,
  input logic open_flt,
  input logic short_flt,
  input logic mismatch,
  input logic confirm_done
);
  // R7
  blank_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_req |=> (!open_flt && !short_flt && !confirm_done && !mismatch && !warn_derate));

  // R10
  idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !blanking) |=> $stable(open_flt));

  // R10
  idle_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !blanking) |=> $stable(confirm_done));

  // R4
  open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_flt) |-> $past(qual && open_hit));

  // R4
  short_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flt) |-> $past(qual && short_hit));

  // R6
  mm_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> !loop_ok);

  // R8
  ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_ok) |-> $past(qual));
endmodule

bind contact_qualifier cq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .blank_req(blank_req), .smp_vld(smp_vld),
  .blanking(blanking), .qual(qual), .open_hit(open_hit), .short_hit(short_hit),
  .loop_ok(loop_ok), .warn_derate(warn_derate), .open_flt(open_flt),
  .short_flt(short_flt), .mismatch(mismatch), .confirm_done(confirm_done)
);

// File: tb/contact_qualifier_bench.sv
`timescale 1ns/1ps
module contact_qualifier_bench;
  localparam int DW = 12, KW = 4, M = 8, N = 5, BLANK = 16, CONF = 4;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, smp_vld, blank_req;
  logic [DW-1:0] i_meas, v_meas, i_cmd;
  logic [DW-1:0] ovs, ovc, ois, oic, svs, svc, sis, sic, tset, tclr;
  logic [KW-1:0] kset, kclr;
  logic loop_ok, warn_derate, open_flt, short_flt, mismatch, confirm_done;

  contact_qualifier #(.DW(DW), .KW(KW), .M_WIN(M), .N_HIT(N),
                      .BLANK_CYC(BLANK), .CONF_N(CONF)) u_contact_qualifier (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .i_meas(i_meas), .v_meas(v_meas),
    .i_cmd(i_cmd), .blank_req(blank_req),
    .open_v_set(ovs), .open_v_clr(ovc), .open_i_set(ois), .open_i_clr(oic),
    .short_v_set(svs), .short_v_clr(svc), .short_i_set(sis), .short_i_clr(sic),
    .warn_k_set(kset), .warn_k_clr(kclr), .tol_set(tset), .tol_clr(tclr),
    .loop_ok(loop_ok), .warn_derate(warn_derate), .open_flt(open_flt),
    .short_flt(short_flt), .mismatch(mismatch), .confirm_done(confirm_done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Behavioural reference model
  bit m_oh, m_sh, m_wh, m_mh;
  bit oq[$];
  bit sq[$];
  int m_bcnt = 0, m_run = 0;

  function automatic int qcount(ref bit q[$]);
    int c = 0;
    foreach (q[k]) c += q[k];
    return c;
  endfunction

  function automatic bit m_open();  return qcount(oq) >= N; endfunction
  function automatic bit m_short(); return qcount(sq) >= N; endfunction
  function automatic bit m_ok();
    return (m_run == CONF) && !m_open() && !m_short() && !m_mh;
  endfunction

  task automatic model_edge();
    int iv = i_meas, vv = v_meas, dv;
    bit blanked = blank_req || (m_bcnt != 0);
    bit oh, sh, wh, mh;
    if (blanked) begin
      m_oh = 0; m_sh = 0; m_wh = 0; m_mh = 0; oq.delete(); sq.delete(); m_run = 0;
    end else if (smp_vld) begin
      oh = m_oh ? (vv >= ovc && iv <= oic) : (vv >= ovs && iv <= ois);
      sh = m_sh ? (vv <= svc && iv >= sic) : (vv <= svs && iv >= sis);
      wh = m_wh ? (vv > iv * kclr) : (vv > iv * kset);
      dv = iv > i_cmd ? iv - int'(i_cmd) : int'(i_cmd) - iv;
      mh = m_mh ? (dv > tclr) : (dv > tset);
      oq.push_back(oh); if (oq.size() > M) void'(oq.pop_front());
      sq.push_back(sh); if (sq.size() > M) void'(sq.pop_front());
      if (oh || sh || mh) m_run = 0;
      else if (m_run < CONF) m_run++;
      m_oh = oh; m_sh = sh; m_wh = wh; m_mh = mh;
    end
    if (blank_req) m_bcnt = BLANK;
    else if (m_bcnt != 0) m_bcnt--;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(open_flt == m_open(),   "R2/R4 open_flt",  open_flt,  m_open());
    chk(short_flt == m_short(), "R3/R4 short_flt", short_flt, m_short());
    chk(warn_derate == m_wh,    "R5 warn_derate",  warn_derate, m_wh);
    chk(mismatch == m_mh,       "R6 mismatch",     mismatch,  m_mh);
    chk(confirm_done == (m_run == CONF), "R7/R8 confirm_done", confirm_done, m_run == CONF);
    chk(loop_ok == m_ok(),      "R9 loop_ok",      loop_ok,   m_ok());
  endtask

  // Called at a negedge: drive, let one edge pass, compare at next negedge.
  task automatic step(bit vld, int iv, int vv, bit blk);
    smp_vld = vld; i_meas = DW'(iv); v_meas = DW'(vv); blank_req = blk;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic clean_smp();  step(1, 1000, 2000, 0); endtask
  task automatic open_smp();   step(1, 50, 3500, 0);   endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    rst_n = 0; smp_vld = 0; blank_req = 0; i_meas = 0; v_meas = 0;
    i_cmd = 1000; ovs = 3000; ovc = 2800; ois = 100; oic = 150;
    svs = 200; svc = 300; sis = 3000; sic = 2800; kset = 4; kclr = 3;
    tset = 200; tclr = 150;
    repeat (3) @(negedge clk);
    // R1
    chk({loop_ok, warn_derate, open_flt, short_flt, mismatch, confirm_done} == 0,
        "R1 reset outputs", {loop_ok, warn_derate, open_flt, short_flt, mismatch, confirm_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(loop_ok == 0, "R1 loop_ok after reset", loop_ok, 0);

    // R8: confirmation run
    repeat (3) clean_smp();
    chk(loop_ok == 0, "R8 loop_ok before run complete", loop_ok, 0);
    clean_smp();
    chk(loop_ok == 1, "R8 loop_ok after run", loop_ok, 1);

    // R10: idle cycles leave state untouched
    repeat (5) step(0, 50, 3500, 0);
    chk(loop_ok == 1 && open_flt == 0, "R10 idle ignored", loop_ok, 1);

    // R4: sparse spikes never trip
    repeat (3) begin
      open_smp(); clean_smp(); clean_smp(); clean_smp();
    end
    chk(open_flt == 0, "R4 spikes no fault", open_flt, 0);

    // R4/R2: sustained open trips
    repeat (5) open_smp();
    chk(open_flt == 1, "R4 sustained open", open_flt, 1);
    chk(loop_ok == 0, "R9 open blocks loop_ok", loop_ok, 0);
    // R2: hysteresis band keeps the hit
    repeat (8) step(1, 120, 2900, 0);
    chk(open_flt == 1, "R2 hysteresis hold", open_flt, 1);

    // R7: blanking discards samples and clears state
    step(1, 50, 3500, 1);
    repeat (BLANK) open_smp();
    chk(open_flt == 0 && confirm_done == 0, "R7 blank cleared", open_flt, 0);
    step(1, 120, 2900, 0);
    chk(open_flt == 0, "R2 band does not set", open_flt, 0);
    repeat (3) clean_smp();
    chk(loop_ok == 0, "R8 reconfirm pending", loop_ok, 0);
    clean_smp();
    chk(loop_ok == 1, "R8 reconfirm done", loop_ok, 1);

    // R5: warning keeps permission
    step(1, 1000, 4095, 0);
    chk(warn_derate == 1 && loop_ok == 1, "R5 warn keeps loop_ok", warn_derate, 1);
    step(1, 1000, 3500, 0);
    chk(warn_derate == 1, "R5 warn hold band", warn_derate, 1);
    clean_smp();
    chk(warn_derate == 0, "R5 warn clears", warn_derate, 0);

    // R6: mismatch
    step(1, 1300, 2000, 0);
    chk(mismatch == 1 && loop_ok == 0, "R6 mismatch blocks", mismatch, 1);
    step(1, 1170, 2000, 0);
    chk(mismatch == 1, "R6 mismatch hold band", mismatch, 1);

    // R3: sustained short
    repeat (5) step(1, 3500, 100, 0);
    chk(short_flt == 1 && loop_ok == 0, "R3 short fault", short_flt, 1);
    repeat (8) clean_smp();
    chk(short_flt == 0 && loop_ok == 1, "R3 short recovers", short_flt, 0);

    // Mixed pseudo-random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int cls, jit;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cls = lfsr[2:0];
      jit = int'(lfsr[10:4]) * 3;
      case (cls)
        0, 1, 2: step(lfsr[11] | lfsr[12], 900 + jit / 2, 1800 + jit, (lfsr[15:9] == 0));
        3:       step(1, 40 + jit / 4, 2700 + jit * 2, 0);
        4:       step(1, 2750 + jit * 2, 150 + jit / 2, 0);
        5:       step(1, 1000, 3000 + jit * 3, 0);
        6:       step(1, 1100 + jit, 2500, 0);
        default: step(lfsr[13], 50, 3500, lfsr[14] & lfsr[5] & lfsr[6]);
      endcase
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule